// File: doc/BRIEF.md
# Transmit De-emphasis Selector

This block chooses the transmit de-emphasis level for one PCI Express port and drives it onto every lane. It also supplies the de-emphasis bit the port places in its outgoing training sets. At 2.5 GT/s the level is always -3.5 dB. At 5.0 GT/s it is either -3.5 dB or -6.0 dB. The port's role decides which value wins: an upstream-facing port advertises its own configured preference but takes whatever its link partner decides, while a downstream-facing port ignores what the partner asks for and imposes its own configured value.

The link training state machine reports its state on a 3-bit input. In normal operation the choice is made during Recovery. The partner's training-set value is collected while the port is in Recovery, and the applied level changes only in the cycle the port leaves Recovery. In Polling.Compliance the configured value is applied directly. Every encoding uses 1 for -3.5 dB and 0 for -6.0 dB.

Top module: `deemph_select`

## Requirements
- R1: After a synchronous reset, every lane output and the advertised output read 1 (-3.5 dB).
- R2: While the rate input is 0 (2.5 GT/s), all lane outputs read 1 one clock later, whatever the configuration, role, partner value or state.
- R3: The advertised output equals the configuration bit sampled at the previous clock edge, for both roles.
- R4: At 5.0 GT/s, a downstream-facing port (role input 1) that leaves Recovery (state code 5) applies its configuration bit, whatever the partner sent.
- R5: At 5.0 GT/s, an upstream-facing port (role input 0) that leaves Recovery applies the last partner value that was marked valid during that Recovery visit.
- R6: An upstream-facing port that saw no valid partner value during a Recovery visit applies its configuration bit on leaving.
- R7: Outside Recovery and Polling.Compliance at 5.0 GT/s, the applied level does not change. Partner inputs and configuration changes seen in L0 (state code 4) have no effect on the lanes.
- R8: In Polling.Compliance (state code 2) at 5.0 GT/s, the lanes take the configuration bit one clock later.
- R9: All lane outputs always carry the same value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_5g | input | 1 | 1 = 5.0 GT/s, 0 = 2.5 GT/s |
| role_dsp | input | 1 | 1 = downstream-facing port, 0 = upstream-facing port |
| cfg_deemph | input | 1 | Configured selectable de-emphasis (1 = -3.5 dB, 0 = -6.0 dB) |
| partner_deemph | input | 1 | De-emphasis bit from a received training set |
| partner_valid | input | 1 | partner_deemph is valid this cycle |
| ltssm_state | input | 3 | 0 Detect, 1 Polling, 2 Polling.Compliance, 3 Configuration, 4 L0, 5 Recovery, 6 L0s, 7 L1 |
| lane_deemph | output | LANES | Applied de-emphasis, one bit per lane |
| adv_deemph | output | 1 | De-emphasis bit to advertise in outgoing training sets |

## Verification
The hardest case to reach is an upstream-facing port that gets several partner values inside one Recovery visit, and whose applied level must be the last of them and not the first. The stimulus enters Recovery, sends a partner value, holds a cycle without one, and then sends the opposite value before moving to L0. This run is repeated with no partner value at all, so the fallback to the configuration bit is exercised. It is also repeated with a configuration that disagrees with the partner, so that following the partner and using the local setting lead to different outputs.

// File: rtl/deemph_pkg.sv
package deemph_pkg;
  typedef enum logic [2:0] {
    ST_DETECT   = 3'd0,
    ST_POLLING  = 3'd1,
    ST_POLLCOMP = 3'd2,
    ST_CONFIG   = 3'd3,
    ST_L0       = 3'd4,
    ST_RECOVERY = 3'd5,
    ST_L0S      = 3'd6,
    ST_L1       = 3'd7
  } ltssm_e;

  localparam logic DE_3P5 = 1'b1;
  localparam logic DE_6P0 = 1'b0;
endpackage

// File: rtl/deemph_partner_latch.sv
module deemph_partner_latch (
  input  logic clk,
  input  logic rst,
  input  logic enter_rec,
  input  logic in_rec,
  input  logic cfg_deemph,
  input  logic partner_deemph,
  input  logic partner_valid,
  output logic pending
);
  import deemph_pkg::*;

  logic pend_q;

  // A new Recovery visit starts from the local setting. A valid training
  // set seen in that cycle or later overrides it.
  always_ff @(posedge clk) begin
    if (rst)
      pend_q <= DE_3P5;
    else if (in_rec && partner_valid)
      pend_q <= partner_deemph;
    else if (enter_rec)
      pend_q <= cfg_deemph;
  end

  assign pending = pend_q;

  assert_capture_R5: assert property (@(posedge clk) disable iff (rst)
    (in_rec && partner_valid) |=> (pend_q == $past(partner_deemph)));

  assert_fallback_R6: assert property (@(posedge clk) disable iff (rst)
    (enter_rec && !partner_valid) |=> (pend_q == $past(cfg_deemph)));
endmodule

// File: rtl/deemph_apply.sv
module deemph_apply #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rate_5g,
  input  logic             role_dsp,
  input  logic             cfg_deemph,
  input  logic             pending,
  input  logic             leave_rec,
  input  logic             in_comp,
  input  logic             in_l0,
  output logic [LANES-1:0] lane_deemph,
  output logic             adv_deemph
);
  import deemph_pkg::*;

  logic applied_q;
  logic adv_q;

  always_ff @(posedge clk) begin
    if (rst)
      applied_q <= DE_3P5;
    else if (!rate_5g)
      applied_q <= DE_3P5;
    else if (in_comp)
      applied_q <= cfg_deemph;
    else if (leave_rec)
      applied_q <= role_dsp ? cfg_deemph : pending;
  end

  always_ff @(posedge clk) begin
    if (rst)
      adv_q <= DE_3P5;
    else
      adv_q <= cfg_deemph;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_deemph[g] = applied_q;
  end

  assign adv_deemph = adv_q;

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (applied_q == DE_3P5 && adv_q == DE_3P5));

  assert_gen1_fixed_R2: assert property (@(posedge clk) disable iff (rst)
    !rate_5g |=> (applied_q == DE_3P5));

  assert_adv_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (adv_q == $past(cfg_deemph)));

  assert_dsp_own_R4: assert property (@(posedge clk) disable iff (rst)
    (leave_rec && rate_5g && role_dsp && !in_comp) |=> (applied_q == $past(cfg_deemph)));

  assert_usp_follow_R5: assert property (@(posedge clk) disable iff (rst)
    (leave_rec && rate_5g && !role_dsp && !in_comp) |=> (applied_q == $past(pending)));

  assert_l0_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (in_l0 && $past(in_l0) && rate_5g && $past(rate_5g) && !$past(leave_rec))
      |-> $stable(applied_q));

  assert_comp_R8: assert property (@(posedge clk) disable iff (rst)
    (in_comp && rate_5g) |=> (applied_q == $past(cfg_deemph)));
endmodule

// File: rtl/deemph_select.sv
module deemph_select #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rate_5g,
  input  logic             role_dsp,
  input  logic             cfg_deemph,
  input  logic             partner_deemph,
  input  logic             partner_valid,
  input  logic [2:0]       ltssm_state,
  output logic [LANES-1:0] lane_deemph,
  output logic             adv_deemph
);
  import deemph_pkg::*;

  ltssm_e st;
  logic   in_rec;
  logic   in_rec_q;
  logic   enter_rec;
  logic   leave_rec;
  logic   in_comp;
  logic   in_l0;
  logic   pending;

  assign st        = ltssm_e'(ltssm_state);
  assign in_rec    = (st == ST_RECOVERY);
  assign in_comp   = (st == ST_POLLCOMP);
  assign in_l0     = (st == ST_L0);
  assign enter_rec = in_rec && !in_rec_q;
  assign leave_rec = in_rec_q && !in_rec;

  always_ff @(posedge clk) begin
    if (rst)
      in_rec_q <= 1'b0;
    else
      in_rec_q <= in_rec;
  end

  deemph_partner_latch u_latch (
    .clk            (clk),
    .rst            (rst),
    .enter_rec      (enter_rec),
    .in_rec         (in_rec),
    .cfg_deemph     (cfg_deemph),
    .partner_deemph (partner_deemph),
    .partner_valid  (partner_valid),
    .pending        (pending)
  );

  deemph_apply #(.LANES(LANES)) u_apply (
    .clk         (clk),
    .rst         (rst),
    .rate_5g     (rate_5g),
    .role_dsp    (role_dsp),
    .cfg_deemph  (cfg_deemph),
    .pending     (pending),
    .leave_rec   (leave_rec),
    .in_comp     (in_comp),
    .in_l0       (in_l0),
    .lane_deemph (lane_deemph),
    .adv_deemph  (adv_deemph)
  );

  assert_lanes_agree_R9: assert property (@(posedge clk) disable iff (rst)
    ($countones(lane_deemph) == 0) || ($countones(lane_deemph) == LANES));
endmodule

// File: tb/deemph_select_bench.sv
module deemph_select_bench;
  localparam int LANES = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rate_5g = 1'b1;
  logic role_dsp = 1'b0;
  logic cfg_deemph = 1'b1;
  logic partner_deemph = 1'b0;
  logic partner_valid = 1'b0;
  logic [2:0] ltssm_state = 3'd0;
  logic [LANES-1:0] lane_deemph;
  logic adv_deemph;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  deemph_select #(.LANES(LANES)) u_deemph_select (
    .clk            (clk),
    .rst            (rst),
    .rate_5g        (rate_5g),
    .role_dsp       (role_dsp),
    .cfg_deemph     (cfg_deemph),
    .partner_deemph (partner_deemph),
    .partner_valid  (partner_valid),
    .ltssm_state    (ltssm_state),
    .lane_deemph    (lane_deemph),
    .adv_deemph     (adv_deemph)
  );

  task automatic go(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_lanes(input string req, input logic exp);
    checks++;
    if (lane_deemph !== {LANES{exp}}) begin
      fails++;
      $display("FAIL %s lanes actual=%b expected=%b", req, lane_deemph, {LANES{exp}});
    end
  endtask

  task automatic chk_adv(input string req, input logic exp);
    checks++;
    if (adv_deemph !== exp) begin
      fails++;
      $display("FAIL %s adv actual=%b expected=%b", req, adv_deemph, exp);
    end
  endtask

  // Recovery visit: n_tx partner values (first a, then b), then back to L0.
  task automatic visit(input int n_tx, input logic a, input logic b);
    ltssm_state = 3'd5;
    go(1);
    if (n_tx > 0) begin
      partner_valid = 1'b1; partner_deemph = a; go(1);
      partner_valid = 1'b0; partner_deemph = ~a; go(1);
    end
    if (n_tx > 1) begin
      partner_valid = 1'b1; partner_deemph = b; go(1);
      partner_valid = 1'b0; go(1);
    end
    ltssm_state = 3'd4;
    go(2);
  endtask

  task automatic t_reset;
    chk_lanes("R1", 1'b1);
    chk_adv("R1", 1'b1);
    chk_lanes("R9", 1'b1);
  endtask

  task automatic t_adv;
    cfg_deemph = 1'b0; go(1);
    chk_adv("R3", 1'b0);
    role_dsp = 1'b1; cfg_deemph = 1'b1; go(1);
    chk_adv("R3", 1'b1);
    role_dsp = 1'b0;
  endtask

  task automatic t_dsp;
    role_dsp = 1'b1;
    cfg_deemph = 1'b0; visit(1, 1'b1, 1'b1);
    chk_lanes("R4", 1'b0);
    cfg_deemph = 1'b1; visit(1, 1'b0, 1'b0);
    chk_lanes("R4", 1'b1);
    role_dsp = 1'b0;
  endtask

  task automatic t_usp;
    cfg_deemph = 1'b1; visit(2, 1'b1, 1'b0);
    chk_lanes("R5", 1'b0);
    cfg_deemph = 1'b0; visit(1, 1'b1, 1'b1);
    chk_lanes("R5", 1'b1);
    cfg_deemph = 1'b0; visit(0, 1'b1, 1'b1);
    chk_lanes("R6", 1'b0);
  endtask

  task automatic t_l0_hold;
    // lanes at 0 from previous visit
    cfg_deemph = 1'b1;
    partner_valid = 1'b1; partner_deemph = 1'b1; go(3);
    partner_valid = 1'b0;
    chk_lanes("R7", 1'b0);
    chk_adv("R7", 1'b1);
  endtask

  task automatic t_gen1;
    role_dsp = 1'b1; cfg_deemph = 1'b0; visit(0, 1'b0, 1'b0);
    chk_lanes("R4", 1'b0);
    rate_5g = 1'b0; go(1);
    chk_lanes("R2", 1'b1);
    visit(1, 1'b0, 1'b0);
    chk_lanes("R2", 1'b1);
    rate_5g = 1'b1; go(2);
    chk_lanes("R7", 1'b1);
    role_dsp = 1'b0;
  endtask

  task automatic t_comp;
    ltssm_state = 3'd2; cfg_deemph = 1'b0; go(1);
    chk_lanes("R8", 1'b0);
    cfg_deemph = 1'b1; go(1);
    chk_lanes("R8", 1'b1);
    ltssm_state = 3'd4; go(1);
  endtask

  initial begin
    go(3);
    rst = 1'b0;
    ltssm_state = 3'd4;
    t_reset;
    t_adv;
    t_dsp;
    t_usp;
    t_l0_hold;
    t_gen1;
    t_comp;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule